// File: doc/BRIEF.md
# Pointer-Indirect Load/Store Sequencer

This unit handles the indirect load and store instructions of a small 8-bit core that address data memory through one of three 16-bit pointer register pairs (X, Y, Z). It receives the opcode word together with the current pointer values and the store data. It decodes direction, destination or source register, pointer pair and update mode. It then forms the data address and issues one data-memory access. On completion it returns the loaded byte for the register file and, where the mode calls for it, the updated pointer value for the pointer pair.

Three update modes share one opcode group: the pointer is used as is, used and then incremented, or decremented and then used. A second opcode group adds an unsigned 6-bit displacement, spread over several instruction bits, to the Y or Z pointer. Each address is steered to one of three regions: the register-file alias, the I/O window or plain RAM. An address past the configured RAM end is reported as a fault, and no access takes place. Every accepted instruction occupies two cycles.

Top module: `ptr_lsu`

## Requirements
- R1: During and after a synchronous reset, busy, mem_req, done, fault, ld_we and pw_we are all 0.
- R2: With op_valid high, the accepted opcodes are the group 1001 00sr rrrr nnnn, with nnnn = 1100/1101/1110 (X unchanged / post-increment / pre-decrement), 1001/1010 (Y post-inc / pre-dec) or 0001/0010 (Z post-inc / pre-dec), and the displacement group 10q0 qqsr rrrr bqqq (b=1 Y, b=0 Z). In both groups s is bit 9 and r is bits 8:4. Any other opcode is ignored: busy and mem_req stay 0 and no done follows.
- R3: The access address is the pointer for the unchanged and post-increment modes, pointer-1 for pre-decrement, and pointer+q for the displacement form, where q = {op[13], op[11:10], op[2:0]} is unsigned. All arithmetic wraps at 16 bits.
- R4: An opcode accepted at a rising edge while busy is 0 drives busy and the access outputs high for exactly the next cycle. done follows for exactly the cycle after that, so each instruction takes two cycles.
- R5: op_valid is ignored while busy is 1.
- R6: A store (s=1) drives mem_we=1 and mem_wdata equal to st_data as sampled at acceptance, and never raises ld_we.
- R7: A load (s=0) raises ld_we together with done. ld_reg carries r, and ld_data carries mem_rdata as sampled at the end of the request cycle.
- R8: pw_we rises with done only for the post-increment and pre-decrement modes. It carries pw_sel (0=X, 1=Y, 2=Z) and pw_value = pointer+1 or pointer-1. The unchanged and displacement forms never raise it.
- R9: mem_region is 0 for addresses 0-31, 1 for 32-255 and 2 for 256 up to RAM_END.
- R10: An address above RAM_END raises no mem_req. It gives done with fault=1, and neither ld_we nor pw_we rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Opcode offered this cycle |
| op_word | input | 16 | Instruction word |
| ptr_x | input | 16 | Current X pointer pair |
| ptr_y | input | 16 | Current Y pointer pair |
| ptr_z | input | 16 | Current Z pointer pair |
| st_data | input | 8 | Value of the source register for stores |
| mem_rdata | input | 8 | Read data, valid in the request cycle |
| busy | output | 1 | Instruction in its second cycle |
| mem_req | output | 1 | Data access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 8 | Write data |
| mem_region | output | 2 | 0 register alias, 1 I/O, 2 RAM |
| done | output | 1 | Instruction complete |
| fault | output | 1 | Address past RAM end (with done) |
| ld_we | output | 1 | Register write for a load |
| ld_reg | output | 5 | Destination register index |
| ld_data | output | 8 | Loaded byte |
| pw_we | output | 1 | Pointer write-back strobe |
| pw_sel | output | 2 | Pointer pair to update |
| pw_value | output | 16 | Updated pointer value |

## Verification
The access outputs (mem_req, mem_addr, mem_we, mem_wdata, mem_region) and busy are due one edge after acceptance. done, fault, ld_we, ld_data and the pointer write-back are due one edge later. The bench drives each opcode on a falling edge and samples the first group on the next falling edge and the second group on the one after, so each check sits mid-cycle in the cycle where its result is due. Ignored opcodes, including one offered while busy, are checked over the same two-cycle window, where nothing may appear.

// File: rtl/ptr_lsu_pkg.sv
package ptr_lsu_pkg;

  localparam int REG_IDX_W = 5;
  localparam int DISP_W    = 6;
  localparam int NUM_PTR   = 3;

  typedef enum logic [1:0] {
    PSEL_X = 2'd0,
    PSEL_Y = 2'd1,
    PSEL_Z = 2'd2
  } ptr_sel_e;

  typedef enum logic [1:0] {
    UPD_KEEP = 2'd0,
    UPD_INC  = 2'd1,
    UPD_DEC  = 2'd2,
    UPD_DISP = 2'd3
  } upd_mode_e;

  typedef enum logic [1:0] {
    RGN_REGS = 2'd0,
    RGN_IO   = 2'd1,
    RGN_RAM  = 2'd2
  } region_e;

  typedef struct packed {
    logic                 legal;
    logic                 store;
    ptr_sel_e             sel;
    upd_mode_e            mode;
    logic [REG_IDX_W-1:0] ridx;
    logic [DISP_W-1:0]    disp;
  } dec_t;

endpackage

// File: rtl/ptr_lsu_decode.sv
module ptr_lsu_decode
  import ptr_lsu_pkg::*;
(
  input  logic [15:0] op,
  output dec_t        dec
);

  logic grp_ind;
  logic grp_disp;

  always_comb begin
    grp_ind  = (op[15:10] == 6'b100100);
    grp_disp = (op[15:14] == 2'b10) && !op[12];

    dec       = '0;
    dec.store = op[9];
    dec.ridx  = op[8:4];
    dec.sel   = PSEL_X;
    dec.mode  = UPD_KEEP;

    if (grp_ind) begin
      dec.legal = 1'b1;
      unique case (op[3:0])
        4'b1100: begin dec.sel = PSEL_X; dec.mode = UPD_KEEP; end
        4'b1101: begin dec.sel = PSEL_X; dec.mode = UPD_INC;  end
        4'b1110: begin dec.sel = PSEL_X; dec.mode = UPD_DEC;  end
        4'b1001: begin dec.sel = PSEL_Y; dec.mode = UPD_INC;  end
        4'b1010: begin dec.sel = PSEL_Y; dec.mode = UPD_DEC;  end
        4'b0001: begin dec.sel = PSEL_Z; dec.mode = UPD_INC;  end
        4'b0010: begin dec.sel = PSEL_Z; dec.mode = UPD_DEC;  end
        default: dec.legal = 1'b0;
      endcase
    end else if (grp_disp) begin
      dec.legal = 1'b1;
      dec.mode  = UPD_DISP;
      dec.sel   = op[3] ? PSEL_Y : PSEL_Z;
      dec.disp  = {op[13], op[11:10], op[2:0]};
    end
  end

endmodule

// File: rtl/ptr_lsu_agen.sv
module ptr_lsu_agen
  import ptr_lsu_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int REG_TOP = 32,
  parameter int IO_TOP  = 256,
  parameter int RAM_END = 16'h08FF
) (
  input  logic [ADDR_W-1:0] ptr,
  input  upd_mode_e         mode,
  input  logic [DISP_W-1:0] disp,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] next_ptr,
  output logic              wb_en,
  output region_e           region,
  output logic              oob
);

  localparam logic [ADDR_W-1:0] ONE     = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] REG_LIM = ADDR_W'(REG_TOP);
  localparam logic [ADDR_W-1:0] IO_LIM  = ADDR_W'(IO_TOP);
  localparam logic [ADDR_W-1:0] END_LIM = ADDR_W'(RAM_END);

  logic [ADDR_W-1:0] ptr_inc;
  logic [ADDR_W-1:0] ptr_dec;
  logic [ADDR_W-1:0] ptr_off;

  always_comb begin
    ptr_inc = ptr + ONE;
    ptr_dec = ptr - ONE;
    ptr_off = ptr + {{(ADDR_W-DISP_W){1'b0}}, disp};

    unique case (mode)
      UPD_DEC:  addr = ptr_dec;
      UPD_DISP: addr = ptr_off;
      default:  addr = ptr;
    endcase

    next_ptr = (mode == UPD_DEC) ? ptr_dec : ptr_inc;
    wb_en    = (mode == UPD_INC) || (mode == UPD_DEC);

    if (addr < REG_LIM)     region = RGN_REGS;
    else if (addr < IO_LIM) region = RGN_IO;
    else                    region = RGN_RAM;

    oob = (addr > END_LIM);
  end

endmodule

// File: rtl/ptr_lsu.sv
module ptr_lsu
  import ptr_lsu_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int REG_TOP = 32,
  parameter int IO_TOP  = 256,
  parameter int RAM_END = 16'h08FF
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 op_valid,
  input  logic [15:0]          op_word,
  input  logic [ADDR_W-1:0]    ptr_x,
  input  logic [ADDR_W-1:0]    ptr_y,
  input  logic [ADDR_W-1:0]    ptr_z,
  input  logic [DATA_W-1:0]    st_data,
  input  logic [DATA_W-1:0]    mem_rdata,
  output logic                 busy,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [DATA_W-1:0]    mem_wdata,
  output logic [1:0]           mem_region,
  output logic                 done,
  output logic                 fault,
  output logic                 ld_we,
  output logic [REG_IDX_W-1:0] ld_reg,
  output logic [DATA_W-1:0]    ld_data,
  output logic                 pw_we,
  output logic [1:0]           pw_sel,
  output logic [ADDR_W-1:0]    pw_value
);

  // pointer bank gathered into an array so selection is an index
  logic [ADDR_W-1:0] ptr_bank [NUM_PTR];
  logic [ADDR_W-1:0] ptr_in   [NUM_PTR];

  assign ptr_in[0] = ptr_x;
  assign ptr_in[1] = ptr_y;
  assign ptr_in[2] = ptr_z;

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_bank
    assign ptr_bank[g] = ptr_in[g];
  end

  dec_t              dec;
  logic [ADDR_W-1:0] sel_ptr;
  logic [ADDR_W-1:0] a_addr;
  logic [ADDR_W-1:0] a_next;
  logic              a_wb;
  region_e           a_region;
  logic              a_oob;
  logic              accept;

  ptr_lsu_decode u_dec (
    .op  (op_word),
    .dec (dec)
  );

  assign sel_ptr = (dec.sel == PSEL_Y) ? ptr_bank[1] :
                   (dec.sel == PSEL_Z) ? ptr_bank[2] : ptr_bank[0];

  ptr_lsu_agen #(
    .ADDR_W  (ADDR_W),
    .REG_TOP (REG_TOP),
    .IO_TOP  (IO_TOP),
    .RAM_END (RAM_END)
  ) u_agen (
    .ptr      (sel_ptr),
    .mode     (dec.mode),
    .disp     (dec.disp),
    .addr     (a_addr),
    .next_ptr (a_next),
    .wb_en    (a_wb),
    .region   (a_region),
    .oob      (a_oob)
  );

  assign accept = op_valid && dec.legal && !busy;

  // state held between the request cycle and the completion cycle
  logic                 hold_oob;
  logic                 hold_store;
  logic                 hold_wb;
  logic [1:0]           hold_sel;
  logic [ADDR_W-1:0]    hold_ptr;
  logic [REG_IDX_W-1:0] hold_reg;

  // request stage
  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      mem_region <= 2'd0;
      hold_oob   <= 1'b0;
      hold_store <= 1'b0;
      hold_wb    <= 1'b0;
      hold_sel   <= 2'd0;
      hold_ptr   <= '0;
      hold_reg   <= '0;
    end else if (accept) begin
      busy       <= 1'b1;
      mem_req    <= !a_oob;
      mem_we     <= dec.store && !a_oob;
      mem_addr   <= a_addr;
      mem_wdata  <= st_data;
      mem_region <= a_region;
      hold_oob   <= a_oob;
      hold_store <= dec.store;
      hold_wb    <= a_wb && !a_oob;
      hold_sel   <= dec.sel;
      hold_ptr   <= a_next;
      hold_reg   <= dec.ridx;
    end else begin
      busy       <= 1'b0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
    end
  end

  // completion stage
  always_ff @(posedge clk) begin
    if (rst) begin
      done     <= 1'b0;
      fault    <= 1'b0;
      ld_we    <= 1'b0;
      ld_reg   <= '0;
      ld_data  <= '0;
      pw_we    <= 1'b0;
      pw_sel   <= 2'd0;
      pw_value <= '0;
    end else begin
      done     <= busy;
      fault    <= busy && hold_oob;
      ld_we    <= busy && !hold_oob && !hold_store;
      pw_we    <= busy && hold_wb;
      if (busy) begin
        ld_reg   <= hold_reg;
        ld_data  <= mem_rdata;
        pw_sel   <= hold_sel;
        pw_value <= hold_ptr;
      end
    end
  end

endmodule

// File: rtl/ptr_lsu_chk.sv
module ptr_lsu_chk #(
  parameter int ADDR_W  = 16,
  parameter int RAM_END = 16'h08FF
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [1:0]        mem_region,
  input logic              done,
  input logic              fault,
  input logic              ld_we,
  input logic              pw_we
);

  localparam logic [ADDR_W-1:0] END_LIM = ADDR_W'(RAM_END);

  p_req_single_r4: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

  p_busy_then_done_r4: assert property (@(posedge clk) disable iff (rst)
    busy |=> (done && !busy));

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_req_in_range_r10: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr <= END_LIM));

  p_fault_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    fault |-> (done && !ld_we && !pw_we));

  p_load_after_read_r7: assert property (@(posedge clk) disable iff (rst)
    ld_we |-> $past(mem_req && !mem_we));

  p_wb_with_done_r8: assert property (@(posedge clk) disable iff (rst)
    pw_we |-> done);

  p_region_regs_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_region == 2'd0) |-> (mem_addr < ADDR_W'(32)));

  p_quiet_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !mem_req && !done));

endmodule

bind ptr_lsu ptr_lsu_chk #(
  .ADDR_W  (ADDR_W),
  .RAM_END (RAM_END)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .busy       (busy),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_region (mem_region),
  .done       (done),
  .fault      (fault),
  .ld_we      (ld_we),
  .pw_we      (pw_we)
);

// File: tb/ptr_lsu_tb.sv
module ptr_lsu_tb;

  localparam int RAM_END = 16'h08FF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [15:0] op_word = '0;
  logic [15:0] ptr_x = '0, ptr_y = '0, ptr_z = '0;
  logic [7:0]  st_data = '0;
  logic [7:0]  mem_rdata;
  logic        busy, mem_req, mem_we, done, fault, ld_we, pw_we;
  logic [15:0] mem_addr, pw_value;
  logic [7:0]  mem_wdata, ld_data;
  logic [1:0]  mem_region, pw_sel;
  logic [4:0]  ld_reg;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  // memory model: combinational read pattern derived from the address
  function automatic logic [7:0] mem_pat(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction
  assign mem_rdata = mem_req ? mem_pat(mem_addr) : 8'h00;

  ptr_lsu u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_word(op_word),
    .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z), .st_data(st_data),
    .mem_rdata(mem_rdata), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_region(mem_region),
    .done(done), .fault(fault), .ld_we(ld_we), .ld_reg(ld_reg),
    .ld_data(ld_data), .pw_we(pw_we), .pw_sel(pw_sel), .pw_value(pw_value)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // kind: 0 X keep, 1 X inc, 2 X dec, 3 Y inc, 4 Y dec, 5 Z inc, 6 Z dec, 7 Y disp, 8 Z disp
  function automatic logic [15:0] build_op(input int kind, input bit s,
                                           input logic [4:0] r, input logic [5:0] q);
    logic [3:0] nib;
    case (kind)
      0: nib = 4'b1100; 1: nib = 4'b1101; 2: nib = 4'b1110;
      3: nib = 4'b1001; 4: nib = 4'b1010; 5: nib = 4'b0001;
      default: nib = 4'b0010;
    endcase
    if (kind >= 7)
      return {2'b10, q[5], 1'b0, q[4:3], s, r, (kind == 7), q[2:0]};
    return {6'b100100, s, r, nib};
  endfunction

  task automatic run_op(input int kind, input bit s, input logic [4:0] r,
                        input logic [5:0] q, input logic [15:0] px,
                        input logic [15:0] py, input logic [15:0] pz,
                        input logic [7:0] sd);
    logic [15:0] p, a, np;
    logic [1:0]  sel, rg;
    bit          inc, dec, oob;
    sel = (kind < 3) ? 2'd0 : ((kind == 3 || kind == 4 || kind == 7) ? 2'd1 : 2'd2);
    p   = (sel == 2'd0) ? px : ((sel == 2'd1) ? py : pz);
    inc = (kind == 1 || kind == 3 || kind == 5);
    dec = (kind == 2 || kind == 4 || kind == 6);
    a   = dec ? p - 16'd1 : ((kind >= 7) ? p + {10'd0, q} : p);
    np  = dec ? p - 16'd1 : p + 16'd1;
    rg  = (a < 16'd32) ? 2'd0 : ((a < 16'd256) ? 2'd1 : 2'd2);
    oob = (a > 16'(RAM_END));

    op_word = build_op(kind, s, r, q);
    ptr_x = px; ptr_y = py; ptr_z = pz; st_data = sd;
    op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    st_data = ~sd;
    chk("R4 busy", busy, 1);
    chk("R10 mem_req", mem_req, !oob);
    if (!oob) begin
      chk("R3 mem_addr", mem_addr, a);
      chk("R9 mem_region", mem_region, rg);
      chk("R6 mem_we", mem_we, s);
      if (s) chk("R6 mem_wdata", mem_wdata, sd);
    end
    @(negedge clk);
    chk("R4 done", done, 1);
    chk("R4 busy clear", busy, 0);
    chk("R10 fault", fault, oob);
    chk("R7 ld_we", ld_we, (!oob && !s));
    if (!oob && !s) begin
      chk("R7 ld_reg", ld_reg, r);
      chk("R7 ld_data", ld_data, mem_pat(a));
    end
    chk("R8 pw_we", pw_we, (!oob && (inc || dec)));
    if (!oob && (inc || dec)) begin
      chk("R8 pw_sel", pw_sel, sel);
      chk("R8 pw_value", pw_value, np);
    end
  endtask

  task automatic run_illegal(input logic [15:0] op);
    op_word = op;
    op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    chk("R2 ignored busy", busy, 0);
    chk("R2 ignored mem_req", mem_req, 0);
    @(negedge clk);
    chk("R2 ignored done", done, 0);
  endtask

  function automatic logic [15:0] rnd_ptr();
    case ($urandom % 4)
      0: return 16'($urandom % 40);
      1: return 16'(200 + $urandom % 100);
      2: return 16'($urandom);
      default: return 16'($urandom % (RAM_END + 2));
    endcase
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 busy", busy, 0);
    chk("R1 mem_req", mem_req, 0);
    chk("R1 done", done, 0);
    chk("R1 fault", fault, 0);
    chk("R1 ld_we", ld_we, 0);
    chk("R1 pw_we", pw_we, 0);
    rst = 1'b0;
    @(negedge clk);

    // directed corners
    run_op(0, 0, 5'd3,  6'd0,  16'h0010, 16'h0, 16'h0, 8'h11); // R9 register alias, R8 no wb
    run_op(1, 0, 5'd31, 6'd0,  16'h001F, 16'h0, 16'h0, 8'h22); // R3 inc at reg/io edge
    run_op(2, 1, 5'd7,  6'd0,  16'h0020, 16'h0, 16'h0, 8'h5C); // R6 store, dec to 0x1F
    run_op(4, 0, 5'd9,  6'd0,  16'h0, 16'h0000, 16'h0, 8'h00); // R10 dec wraps to 0xFFFF
    run_op(7, 0, 5'd12, 6'd63, 16'h0, 16'h00E1, 16'h0, 8'h00); // R3 disp q=63 -> 0x120
    run_op(8, 1, 5'd1,  6'd1,  16'h0, 16'h0, RAM_END[15:0], 8'h77); // R10 disp past end
    run_op(5, 0, 5'd0,  6'd0,  16'h0, 16'h0, RAM_END[15:0], 8'h00); // R9 last RAM byte
    run_op(6, 1, 5'd2,  6'd0,  16'h0, 16'h0, 16'h0100, 8'h99);      // R9 dec into I/O
    run_op(8, 0, 5'd4,  6'd0,  16'h0, 16'h0, 16'h00FF, 8'h00);      // R8 disp q=0 no wb

    // R2: opcodes outside the two groups
    run_illegal(16'h900F);
    run_illegal(16'h9008);
    run_illegal(16'h9004);
    run_illegal(16'h1C00);

    // R5: new opcode offered while busy is ignored
    op_word = build_op(1, 0, 5'd6, 6'd0);
    ptr_x = 16'h0040;
    op_valid = 1'b1;
    @(negedge clk);
    op_word = build_op(3, 1, 5'd8, 6'd0);
    ptr_y = 16'h0300;
    @(negedge clk);
    op_valid = 1'b0;
    chk("R5 first done", done, 1);
    chk("R5 first addr kept", ld_data, mem_pat(16'h0040));
    chk("R5 busy after", busy, 0);
    chk("R5 no request", mem_req, 0);
    @(negedge clk);
    chk("R5 no second done", done, 0);

    // constrained random
    for (int i = 0; i < 400; i++) begin
      run_op(int'($urandom % 9), bit'($urandom % 2), 5'($urandom),
             6'($urandom), rnd_ptr(), rnd_ptr(), rnd_ptr(), 8'($urandom));
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule